// File: doc/BRIEF.md
# Quadword atomic swap unit

This block takes one 32-bit instruction word for a 128-bit atomic swap and checks that it belongs to the swap class. It reads three register specifiers and two ordering bits from the word. It reads the two data registers and the base register through three read ports, and forms the base address from a general register or from the stack pointer. It packs the register pair into a 128-bit store value according to the endianness input. It then runs a locked read followed by a write, to one address, on a simple 128-bit memory port. When the write completes it returns the old memory contents to the register pair through two write ports in one cycle.

Some outcomes end the operation early. A malformed word, or one that names register 31 as a data register, raises an undefined-instruction pulse. A misaligned stack-pointer base raises an alignment-fault pulse. When both data registers are the same register, a mode input picks one of three handling policies. The acquire, release and tag-check attributes are not acted on here: they are presented as outputs while the memory lock is held, for the memory system to use.

Top module: `qswap_unit`

## Requirements
- R1: A word is accepted only when (word & 32'hFF20_FC00) == 32'h1920_8000. Any other word gives a one-cycle `undef_o` pulse, with no memory request and no register write. Operand fields: Rt = bits[4:0], Rn = bits[9:5], Rt2 = bits[20:16], acquire = bit 23, release = bit 22.
- R2: If Rt or Rt2 is 31, the unit pulses `undef_o` and makes no memory request and no register write.
- R3: When Rt equals Rt2 (and neither is 31), `ovl_mode_i` chooses the outcome. 2'b00: the swap is done in memory, only write port A writes, and it writes zero to Rt. 2'b01 or 2'b11: the unit pulses `undef_o` with no access. 2'b10: `done_o` pulses with no access and no write.
- R4: Rn = 31 takes the base address from `sp_i`. If the low four bits of `sp_i` are not zero, the unit pulses `fault_o` and makes no access. Any other Rn takes the base address from general register Rn, with no alignment check.
- R5: While `mem_lock_o` is high, `acq_o` equals bit 23 and `rel_o` equals bit 22 of the word, and `tag_chk_o` is 1 exactly when Rn is not 31. All three are 0 while the lock is low.
- R6: The store value is {X[Rt2], X[Rt]} when `big_endian_i` = 0 and {X[Rt], X[Rt2]} when it is 1.
- R7: The old memory value is returned to the registers. When `big_endian_i` = 0, Rt gets bits[63:0] and Rt2 gets bits[127:64]. When it is 1, Rt gets bits[127:64] and Rt2 gets bits[63:0].
- R8: An access is exactly one read, then one write, to the same address. `mem_lock_o` is high from the read request until the write handshake and low after it. Address and direction hold while `mem_ready_i` is low.
- R9: Both register writes happen in the single cycle in which `done_o` pulses, and that cycle follows the write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept `instr_i` (taken only when the unit is idle) |
| instr_i | input | 32 | Instruction word |
| big_endian_i | input | 1 | Endianness of the access |
| ovl_mode_i | input | 2 | Policy when both data registers are the same register |
| sp_i | input | 64 | Stack pointer value |
| rs_a_o | output | 5 | Read port A address (Rt) |
| rd_a_i | input | 64 | Read port A data |
| rs_b_o | output | 5 | Read port B address (Rt2) |
| rd_b_i | input | 64 | Read port B data |
| rs_n_o | output | 5 | Read port N address (Rn) |
| rd_n_i | input | 64 | Read port N data |
| wr_en_a_o | output | 1 | Write port A enable |
| wr_addr_a_o | output | 5 | Write port A register |
| wr_data_a_o | output | 64 | Write port A data |
| wr_en_b_o | output | 1 | Write port B enable |
| wr_addr_b_o | output | 5 | Write port B register |
| wr_data_b_o | output | 64 | Write port B data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_lock_o | output | 1 | Memory held locked for this unit |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 128 | Write data |
| mem_ready_i | input | 1 | Request accepted (read data valid with it) |
| mem_rdata_i | input | 128 | Read data |
| acq_o | output | 1 | Acquire attribute during the locked access |
| rel_o | output | 1 | Release attribute during the locked access |
| tag_chk_o | output | 1 | Tag-check attribute during the locked access |
| done_o | output | 1 | Operation complete pulse |
| undef_o | output | 1 | Undefined-instruction pulse |
| fault_o | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The swap is run with distinct, non-symmetric 64-bit halves in both endiannesses. A lane swap in packing or in unpacking therefore shows up in memory or in the registers, and each can be told apart from the other. It is run with a general-register base and with a stack-pointer base, so that the base choice and the tag-check flag are separated. It is run with all four ordering-bit combinations, so that a swapped acquire/release lands on a wrong flag. Memory latency varies between zero and three wait cycles to expose handshake and lock-holding errors. The rejection paths (register 31 in each data field, a corrupted fixed bit, a misaligned stack pointer, and the three overlap policies) are each checked for the absence of memory traffic and register writes.

// File: rtl/qswap_unit.sv
module qswap_unit #(
  parameter int XW = 64,
  parameter int RW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic            big_endian_i,
  input  logic [1:0]      ovl_mode_i,
  input  logic [XW-1:0]   sp_i,
  output logic [RW-1:0]   rs_a_o,
  input  logic [XW-1:0]   rd_a_i,
  output logic [RW-1:0]   rs_b_o,
  input  logic [XW-1:0]   rd_b_i,
  output logic [RW-1:0]   rs_n_o,
  input  logic [XW-1:0]   rd_n_i,
  output logic            wr_en_a_o,
  output logic [RW-1:0]   wr_addr_a_o,
  output logic [XW-1:0]   wr_data_a_o,
  output logic            wr_en_b_o,
  output logic [RW-1:0]   wr_addr_b_o,
  output logic [XW-1:0]   wr_data_b_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_lock_o,
  output logic [XW-1:0]   mem_addr_o,
  output logic [2*XW-1:0] mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [2*XW-1:0] mem_rdata_i,
  output logic            acq_o,
  output logic            rel_o,
  output logic            tag_chk_o,
  output logic            done_o,
  output logic            undef_o,
  output logic            fault_o
);
  localparam int QW = 2 * XW;
  localparam int AL = $clog2(QW / 8);
  localparam logic [RW-1:0] RZ = '1;
  localparam logic [31:0] FIX_MASK = 32'hFF20_FC00;
  localparam logic [31:0] FIX_VAL  = 32'h1920_8000;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_RD, S_WR, S_FIN} st_t;
  st_t st;

  logic [31:0]   ins_q;
  logic          be_q;
  logic [1:0]    mode_q;
  logic [XW-1:0] addr_q;
  logic [QW-1:0] sdat_q, ldat_q;
  logic          zero_q, skip_q, undef_q, fault_q;

  logic [RW-1:0] f_rt, f_rt2, f_rn;
  assign f_rt  = ins_q[4:0];
  assign f_rt2 = ins_q[20:16];
  assign f_rn  = ins_q[9:5];

  logic match, bad_reg, overlap, sp_base;
  assign match   = (ins_q & FIX_MASK) == FIX_VAL;
  assign bad_reg = (f_rt == RZ) || (f_rt2 == RZ);
  assign overlap = f_rt == f_rt2;
  assign sp_base = f_rn == RZ;

  logic [XW-1:0] base;
  assign base = sp_base ? sp_i : rd_n_i;

  assign rs_a_o = f_rt;
  assign rs_b_o = f_rt2;
  assign rs_n_o = f_rn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ins_q   <= '0;
      be_q    <= 1'b0;
      mode_q  <= '0;
      addr_q  <= '0;
      sdat_q  <= '0;
      ldat_q  <= '0;
      zero_q  <= 1'b0;
      skip_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          ins_q  <= instr_i;
          be_q   <= big_endian_i;
          mode_q <= ovl_mode_i;
          zero_q <= 1'b0;
          skip_q <= 1'b0;
          st     <= S_DEC;
        end
        S_DEC: begin
          addr_q <= base;
          sdat_q <= be_q ? {rd_a_i, rd_b_i} : {rd_b_i, rd_a_i};
          if (!match || bad_reg || (overlap && mode_q[0])) begin
            undef_q <= 1'b1;
            st      <= S_IDLE;
          end else if (overlap && mode_q == 2'b10) begin
            skip_q <= 1'b1;
            st     <= S_FIN;
          end else if (sp_base && (sp_i[AL-1:0] != '0)) begin
            fault_q <= 1'b1;
            st      <= S_IDLE;
          end else begin
            zero_q <= overlap;
            st     <= S_RD;
          end
        end
        S_RD: if (mem_ready_i) begin
          ldat_q <= mem_rdata_i;
          st     <= S_WR;
        end
        S_WR: if (mem_ready_i) st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st == S_RD) || (st == S_WR);
  assign mem_lock_o  = mem_req_o;
  assign mem_we_o    = st == S_WR;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sdat_q;

  assign acq_o     = mem_lock_o & ins_q[23];
  assign rel_o     = mem_lock_o & ins_q[22];
  assign tag_chk_o = mem_lock_o & ~sp_base;

  assign done_o  = st == S_FIN;
  assign undef_o = undef_q;
  assign fault_o = fault_q;

  logic fin_wr;
  assign fin_wr = done_o & ~skip_q;

  assign wr_en_a_o   = fin_wr;
  assign wr_en_b_o   = fin_wr & ~zero_q;
  assign wr_addr_a_o = f_rt;
  assign wr_addr_b_o = f_rt2;
  assign wr_data_a_o = zero_q ? '0 : (be_q ? ldat_q[QW-1:XW] : ldat_q[XW-1:0]);
  assign wr_data_b_o = be_q ? ldat_q[XW-1:0] : ldat_q[QW-1:XW];

  // R8
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i && !mem_we_o) |=> (mem_lock_o && mem_we_o));
  // R9
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i && mem_we_o) |=> (done_o && !mem_lock_o));
  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R2
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!wr_en_a_o && !wr_en_b_o && !mem_req_o));
  // R9
  pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_b_o |-> (wr_en_a_o && done_o));
  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!mem_req_o && !wr_en_a_o));
  // R5
  flags_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_o || rel_o || tag_chk_o) |-> mem_lock_o);
  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, undef_o, fault_o}));
endmodule

// File: tb/test_qswap_unit.sv
module test_qswap_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, be;
  logic [31:0] instr;
  logic [1:0] mode;
  logic [63:0] sp;
  logic [4:0] rs_a, rs_b, rs_n, wa, wb;
  logic [63:0] wda, wdb;
  logic wea, web, req, we, lock, rdy, acq, rel, tag, done, undef, fault;
  logic [63:0] maddr;
  logic [127:0] mwdata, mrdata;

  logic [63:0] xr [0:31];
  logic [127:0] mem [0:15];
  int lat, wcnt;
  int checks = 0, fails = 0;
  int n_rd, n_wr, n_wa, n_wb, lock_bad;
  logic [63:0] rd_addr, wr_addr;
  logic f_acq, f_rel, f_tag;

  qswap_unit i_qswap_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
    .big_endian_i(be), .ovl_mode_i(mode), .sp_i(sp),
    .rs_a_o(rs_a), .rd_a_i(xr[rs_a]), .rs_b_o(rs_b), .rd_b_i(xr[rs_b]),
    .rs_n_o(rs_n), .rd_n_i(xr[rs_n]),
    .wr_en_a_o(wea), .wr_addr_a_o(wa), .wr_data_a_o(wda),
    .wr_en_b_o(web), .wr_addr_b_o(wb), .wr_data_b_o(wdb),
    .mem_req_o(req), .mem_we_o(we), .mem_lock_o(lock), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_ready_i(rdy), .mem_rdata_i(mrdata),
    .acq_o(acq), .rel_o(rel), .tag_chk_o(tag),
    .done_o(done), .undef_o(undef), .fault_o(fault));

  assign rdy = req && (wcnt == lat);
  assign mrdata = mem[maddr[7:4]];

  always @(posedge clk) begin
    if (req && !rdy) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (req && rdy) begin
      if (!lock) lock_bad <= lock_bad + 1;
      if (we) begin
        mem[maddr[7:4]] <= mwdata;
        n_wr <= n_wr + 1;
        wr_addr <= maddr;
      end else begin
        n_rd <= n_rd + 1;
        rd_addr <= maddr;
        f_acq <= acq; f_rel <= rel; f_tag <= tag;
      end
    end
    if (wea) begin xr[wa] <= wda; n_wa <= n_wa + 1; end
    if (web) begin xr[wb] <= wdb; n_wb <= n_wb + 1; end
  end

  function automatic logic [31:0] mk(input logic a, input logic r,
      input logic [4:0] t2, input logic [4:0] n, input logic [4:0] t);
    return 32'h1920_8000 | {8'h0, a, r, 1'b0, t2, 6'h0, n, t};
  endfunction

  task automatic chk(input string req_s, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req_s, what, act, exp);
    end
  endtask

  // outcome: 1 done, 2 undef, 3 fault, 0 none
  task automatic run(input logic [31:0] w, input logic e, input logic [1:0] m, output int oc);
    n_rd = 0; n_wr = 0; n_wa = 0; n_wb = 0; lock_bad = 0;
    f_acq = 0; f_rel = 0; f_tag = 0;
    @(negedge clk);
    instr = w; be = e; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oc = 0;
    for (int k = 0; k < 40 && oc == 0; k++) begin
      @(negedge clk);
      if (done) oc = 1; else if (undef) oc = 2; else if (fault) oc = 3;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8", "reset req/lock", {req, lock}, 2'b00);
    chk("R9", "reset outcomes", {done, undef, fault, wea, web}, 5'b0);
    chk("R5", "reset flags", {acq, rel, tag}, 3'b0);
  endtask

  task automatic t_swap(input string tg, input logic e, input logic a, input logic r,
      input logic [4:0] t, input logic [4:0] t2, input logic [4:0] n,
      input logic [63:0] base, input int l);
    int oc;
    logic [127:0] old, st;
    logic [63:0] va, vb;
    lat = l;
    va = {32'hA1A2_A3A4, 27'h0, t, 32'h0} ^ 64'h0123_4567_89AB_CDEF;
    vb = 64'hFEDC_BA98_7654_3210 ^ {59'h0, t2};
    xr[t] = va; xr[t2] = vb;
    if (n == 5'd31) sp = base; else xr[n] = base;
    old = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888} ^ {96'h0, base[31:0]};
    mem[base[7:4]] = old;
    st = e ? {va, vb} : {vb, va};
    run(mk(a, r, t2, n, t), e, 2'b00, oc);
    chk("R9", {tg, " done"}, oc, 1);
    chk("R6", {tg, " stored"}, mem[base[7:4]], st);
    chk("R7", {tg, " Rt"}, xr[t], e ? old[127:64] : old[63:0]);
    chk("R7", {tg, " Rt2"}, xr[t2], e ? old[63:0] : old[127:64]);
    chk("R8", {tg, " one rd one wr"}, {n_rd[3:0], n_wr[3:0], lock_bad[3:0]}, 12'h110);
    chk("R4", {tg, " address"}, {rd_addr, wr_addr}, {base, base});
    chk("R5", {tg, " flags"}, {f_acq, f_rel, f_tag}, {a, r, n != 5'd31});
    chk("R9", {tg, " write counts"}, {n_wa[3:0], n_wb[3:0]}, 8'h11);
    chk("R8", {tg, " lock released"}, lock, 1'b0);
  endtask

  task automatic t_reject(input string tg, input string rq, input logic [31:0] w,
      input logic [1:0] m, input int exp_oc);
    int oc;
    run(w, 1'b0, m, oc);
    chk(rq, {tg, " outcome"}, oc, exp_oc);
    chk(rq, {tg, " no access/write"}, {n_rd[3:0], n_wr[3:0], n_wa[3:0], n_wb[3:0]}, 16'h0);
  endtask

  task automatic t_ovl_arb;
    int oc;
    lat = 1;
    xr[7] = 64'hCAFE_0000_BEEF_0007; xr[8] = 64'h90;
    mem[9] = {64'hAAAA, 64'hBBBB};
    run(mk(1'b0, 1'b0, 5'd7, 5'd8, 5'd7), 1'b0, 2'b00, oc);
    chk("R3", "overlap arb done", oc, 1);
    chk("R3", "overlap arb mem", mem[9], {2{64'hCAFE_0000_BEEF_0007}});
    chk("R3", "overlap arb Rt zero", xr[7], 64'h0);
    chk("R3", "overlap arb writes", {n_wa[3:0], n_wb[3:0]}, 8'h10);
  endtask

  initial begin
    int oc;
    for (int i = 0; i < 32; i++) xr[i] = 64'h0;
    for (int i = 0; i < 16; i++) mem[i] = 128'h0;
    rst_n = 0; start = 0; instr = 0; be = 0; mode = 0; sp = 0; lat = 0; wcnt = 0;
    n_rd = 0; n_wr = 0; n_wa = 0; n_wb = 0; lock_bad = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_swap("LE plain", 1'b0, 1'b0, 1'b0, 5'd1, 5'd2, 5'd3, 64'h30, 0);
    t_swap("BE acqrel sp", 1'b1, 1'b1, 1'b1, 5'd4, 5'd5, 5'd31, 64'h50, 2);
    t_swap("LE acq sp", 1'b0, 1'b1, 1'b0, 5'd10, 5'd11, 5'd31, 64'hA0, 3);
    t_swap("BE rel gpr", 1'b1, 1'b0, 1'b1, 5'd20, 5'd0, 5'd12, 64'h1_0000_00C0, 1);
    t_reject("Rt31", "R2", mk(1'b0, 1'b0, 5'd2, 5'd3, 5'd31), 2'b00, 2);
    t_reject("Rt2_31", "R2", mk(1'b1, 1'b0, 5'd31, 5'd3, 5'd1), 2'b00, 2);
    t_reject("bit15 clear", "R1", mk(1'b0, 1'b0, 5'd2, 5'd3, 5'd1) & ~32'h8000, 2'b00, 2);
    t_reject("bit31 set", "R1", mk(1'b0, 1'b0, 5'd2, 5'd3, 5'd1) | 32'h8000_0000, 2'b00, 2);
    t_reject("overlap undef", "R3", mk(1'b0, 1'b0, 5'd6, 5'd3, 5'd6), 2'b01, 2);
    t_reject("overlap mode3", "R3", mk(1'b0, 1'b0, 5'd6, 5'd3, 5'd6), 2'b11, 2);
    t_reject("overlap nop", "R3", mk(1'b0, 1'b0, 5'd6, 5'd3, 5'd6), 2'b10, 1);
    sp = 64'h58;
    t_reject("sp misaligned", "R4", mk(1'b0, 1'b0, 5'd2, 5'd31, 5'd1), 2'b00, 3);
    t_ovl_arb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule